// File: doc/BRIEF.md
# Configuration Space Register File

This block is the storage side of a PCI configuration target. It holds a 256-byte header as 64 dword registers. Each register has a fixed writable mask, so read-only fields always read back their reset contents. Identity fields, header type, base address register layout and expansion ROM layout are set by parameters. The writable masks and reset values of the six base address slots follow from each slot's type, size and start address.

Writes arrive in one cycle as a register index, a byte offset, a length and low-aligned data. The new data is merged into the target register under that register's mask. A dword write of all ones to a base address slot, or a dword write with the upper ROM address bits all ones to the ROM register, is a size query. The register then takes the stored region size as its write mask, so the next read shows the size. Reads are combinational and take a separate index.

Top module: `cfg_space`

## Requirements
- R1: After reset, register 0 reads {device ID, vendor ID}, register 2 reads {class, subclass, programming interface, 8'h00}, register 11 reads {subsystem ID, subsystem vendor ID}, and register 3 bits 23:16 read the header type. Writes never change any of these.
- R2: A read at an index of 64 or more returns 32'hFFFFFFFF. A write at such an index changes no register. Registers that have no defined field read zero and ignore writes.
- R3: In register 1, only bits 15:0 are writable. In register 3, only bits 7:0 are writable.
- R4: With header type 0, register 15 has writable mask 32'h000000FF. With header type 1, register 15 uses 32'hFFFF00FF and register 9 uses 32'hFFF0FFF0.
- R5: Base address slots sit at registers 4 to 9. A used slot resets to its start address masked by 32'hFFFFFFF0 (memory) or 32'hFFFFFFFC (I/O), ORed with read-only type bits: 0 for 32-bit memory, 1 for I/O, 4 for 64-bit memory, plus 8 for a prefetchable memory slot. Only the address-mask bits are writable.
- R6: A 64-bit memory slot also uses the next register as its upper half. The upper half resets to address bits 63:32 and all 32 of its bits are writable.
- R7: A dword write of exactly 32'hFFFFFFFF to a slot register uses the stored size as its write mask. For the lower register this is size bits 31:0, and for the upper half it is size bits 63:32. The register then reads as its read-only bits ORed with that size value. Any other dword value is masked by the address mask as usual.
- R8: The ROM register is register 12. It resets to its start address ORed with the enable flag in bit 0, and its writable mask is 32'hFFFFF800. A dword write whose bits 31:11 are all ones uses the ROM size as its mask instead.
- R9: The following writes are discarded: a length other than 1, 2 or 4; a word write at byte offset 1 or 3; and any write whose offset plus length exceeds 4.
- R10: Byte and word writes place the low data bits at the given byte offset. They change only bits that are both in the addressed bytes and writable, and they never act as size queries.
- R11: An unused slot register reads zero and no write changes it.
- R12: Byte writes of 8'hFF to a slot register go through the address mask, even when they cover every byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset that restores parameter values |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_idx | input | IDX_W | Register index of the write |
| wr_off | input | 2 | Byte offset within the dword |
| wr_len | input | 3 | Access length in bytes (1, 2 or 4) |
| wr_data | input | 32 | Write data, low-aligned |
| rd_idx | input | IDX_W | Register index of the read |
| rd_data | output | 32 | Combinational read data |

## Verification
The bench targets the size-query boundary. Cases include a value one bit short of all ones, all-ones bytes written one at a time, and a query on the upper half of a 64-bit slot whose upper size is zero. A design that detected the query loosely would report a size where an address belongs. One that used the address mask on the upper half would read all ones instead of zero. Misaligned and overlong writes aimed at writable command bits would corrupt them if accepted. An out-of-range index that aliased into the array would overwrite the command register. Both header types are checked, since the bridge masks on registers 9 and 15 differ from the device masks.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

   // fixed header geometry
   localparam int NBAR           = 6;
   localparam int BAR_BASE       = 4;
   localparam int REG_ID         = 0;
   localparam int REG_CMD        = 1;
   localparam int REG_CLASS      = 2;
   localparam int REG_HDR        = 3;
   localparam int REG_BRIDGE_WIN = 9;
   localparam int REG_SUBSYS     = 11;
   localparam int REG_ROM        = 12;
   localparam int REG_IRQ        = 15;
   localparam int ROM_ALIGN      = 11;

   localparam logic [31:0] MEM_AMASK = 32'hFFFF_FFF0;
   localparam logic [31:0] IO_AMASK  = 32'hFFFF_FFFC;

   // base address slot kinds
   localparam logic [1:0] BK_NONE  = 2'd0;
   localparam logic [1:0] BK_MEM32 = 2'd1;
   localparam logic [1:0] BK_IO    = 2'd2;
   localparam logic [1:0] BK_MEM64 = 2'd3;

   // size-query detection flavour per register
   localparam logic [1:0] Q_NONE  = 2'd0;
   localparam logic [1:0] Q_EXACT = 2'd1;
   localparam logic [1:0] Q_ROMHI = 2'd2;

endpackage

// File: rtl/cfg_reg_attr.sv
module cfg_reg_attr
   import cfg_space_pkg::*;
#(
   parameter int                    IDX        = 0,
   parameter logic [15:0]           VENDOR_ID  = 16'h0,
   parameter logic [15:0]           DEVICE_ID  = 16'h0,
   parameter logic [7:0]            CLASS_CODE = 8'h0,
   parameter logic [7:0]            SUBCLASS   = 8'h0,
   parameter logic [7:0]            PROG_IF    = 8'h0,
   parameter logic [15:0]           SUBSYS_VID = 16'h0,
   parameter logic [15:0]           SUBSYS_ID  = 16'h0,
   parameter int                    HDR_TYPE   = 0,
   parameter logic [2*NBAR-1:0]     BAR_KIND   = '0,
   parameter logic [NBAR-1:0]       BAR_PREF   = '0,
   parameter logic [8*NBAR-1:0]     BAR_SZL2   = '0,
   parameter logic [64*NBAR-1:0]    BAR_ADDR   = '0,
   parameter int                    ROM_SZL2   = 0,
   parameter logic [31:0]           ROM_ADDR   = 32'h0,
   parameter bit                    ROM_EN     = 1'b0
) (
   output logic [31:0] rst_val,
   output logic [31:0] wmask,
   output logic [31:0] qmask,
   output logic [1:0]  qkind
);

   localparam bit          IS_BAR = (IDX >= BAR_BASE) && (IDX < BAR_BASE + NBAR);
   localparam int          S      = IS_BAR ? IDX - BAR_BASE : 0;
   localparam int          SP     = (S > 0) ? S - 1 : 0;
   localparam logic [1:0]  KIND   = BAR_KIND[2*S +: 2];
   localparam logic [1:0]  KPREV  = BAR_KIND[2*SP +: 2];
   localparam bit          UPPER  = IS_BAR && (S > 0) && (KPREV == BK_MEM64) && (KIND == BK_NONE);
   localparam logic [63:0] SIZE   = 64'd1 << BAR_SZL2[8*S +: 8];
   localparam logic [63:0] SIZEP  = 64'd1 << BAR_SZL2[8*SP +: 8];
   localparam logic [63:0] ADDR   = BAR_ADDR[64*S +: 64];
   localparam logic [63:0] ADDRP  = BAR_ADDR[64*SP +: 64];
   localparam logic [31:0] AMASK  = (KIND == BK_IO) ? IO_AMASK : MEM_AMASK;
   localparam logic [31:0] TYPEB  = ((KIND == BK_IO)    ? 32'h1 : 32'h0) |
                                    ((KIND == BK_MEM64) ? 32'h4 : 32'h0) |
                                    ((BAR_PREF[S] && KIND != BK_IO) ? 32'h8 : 32'h0);
   localparam logic [31:0] ROM_MASK = ~((32'h1 << ROM_ALIGN) - 32'h1);
   localparam logic [31:0] ROM_SIZE = (ROM_SZL2 == 0) ? 32'h0 : (32'h1 << ROM_SZL2);

   always_comb begin
      rst_val = '0;
      wmask   = '0;
      qmask   = '0;
      qkind   = Q_NONE;
      if (IDX == REG_ID) begin
         rst_val = {DEVICE_ID, VENDOR_ID};
      end else if (IDX == REG_CMD) begin
         wmask = 32'h0000_FFFF;
      end else if (IDX == REG_CLASS) begin
         rst_val = {CLASS_CODE, SUBCLASS, PROG_IF, 8'h00};
      end else if (IDX == REG_HDR) begin
         rst_val = (HDR_TYPE == 1) ? 32'h0001_0000 : 32'h0;
         wmask   = 32'h0000_00FF;
      end else if (IS_BAR && KIND != BK_NONE) begin
         rst_val = (ADDR[31:0] & AMASK) | TYPEB;
         wmask   = AMASK;
         qmask   = SIZE[31:0];
         qkind   = Q_EXACT;
      end else if (UPPER) begin
         rst_val = ADDRP[63:32];
         wmask   = 32'hFFFF_FFFF;
         qmask   = SIZEP[63:32];
         qkind   = Q_EXACT;
      end else if (IDX == REG_BRIDGE_WIN && HDR_TYPE == 1) begin
         wmask = 32'hFFF0_FFF0;
      end else if (IDX == REG_SUBSYS) begin
         rst_val = {SUBSYS_ID, SUBSYS_VID};
      end else if (IDX == REG_ROM && ROM_SZL2 != 0) begin
         rst_val = (ROM_ADDR & ROM_MASK) | {31'h0, ROM_EN};
         wmask   = ROM_MASK;
         qmask   = ROM_SIZE;
         qkind   = Q_ROMHI;
      end else if (IDX == REG_IRQ) begin
         wmask = (HDR_TYPE == 1) ? 32'hFFFF_00FF : 32'h0000_00FF;
      end
   end

endmodule

// File: rtl/cfg_write_merge.sv
module cfg_write_merge
   import cfg_space_pkg::*;
(
   input  logic [31:0] cur,
   input  logic [31:0] wdata,
   input  logic [31:0] wmask,
   input  logic [31:0] qmask,
   input  logic [1:0]  qkind,
   input  logic [1:0]  off,
   input  logic [2:0]  len,
   output logic [31:0] nxt,
   output logic        take
);

   logic [3:0]  lanes;
   logic        shape_ok;
   logic [3:0]  span;
   logic [31:0] bytemask;
   logic [31:0] shifted;
   logic        is_query;
   logic [31:0] clr_m;
   logic [31:0] set_m;

   always_comb begin
      span = {2'b00, off} + {1'b0, len};
      unique case (len)
         3'd1:    begin lanes = 4'b0001 << off; shape_ok = 1'b1;        end
         3'd2:    begin lanes = 4'b0011 << off; shape_ok = !off[0];     end
         3'd4:    begin lanes = 4'b1111;        shape_ok = (off == 2'd0); end
         default: begin lanes = 4'b0000;        shape_ok = 1'b0;        end
      endcase
      take = shape_ok && (span <= 4'd4);
      for (int k = 0; k < 4; k++) begin
         bytemask[8*k +: 8] = {8{lanes[k]}};
      end
      shifted = wdata << {off, 3'b000};
      is_query = (len == 3'd4) &&
                 (((qkind == Q_EXACT) && (&wdata)) ||
                  ((qkind == Q_ROMHI) && (&wdata[31:ROM_ALIGN])));
      clr_m = wmask & bytemask;
      set_m = is_query ? qmask : clr_m;
      nxt   = (cur & ~clr_m) | (shifted & set_m);
   end

endmodule

// File: rtl/cfg_space.sv
module cfg_space
   import cfg_space_pkg::*;
#(
   parameter int                    NREG       = 64,
   parameter int                    IDX_W      = 8,
   parameter logic [15:0]           VENDOR_ID  = 16'hC0DE,
   parameter logic [15:0]           DEVICE_ID  = 16'h5A17,
   parameter logic [7:0]            CLASS_CODE = 8'h04,
   parameter logic [7:0]            SUBCLASS   = 8'h01,
   parameter logic [7:0]            PROG_IF    = 8'h00,
   parameter logic [15:0]           SUBSYS_VID = 16'h7E11,
   parameter logic [15:0]           SUBSYS_ID  = 16'h0042,
   parameter int                    HDR_TYPE   = 0,
   parameter logic [2*NBAR-1:0]     BAR_KIND   = 12'h039,
   parameter logic [NBAR-1:0]       BAR_PREF   = 6'b000100,
   parameter logic [8*NBAR-1:0]     BAR_SZL2   = 48'h00_00_00_14_05_0C,
   parameter logic [64*NBAR-1:0]    BAR_ADDR   = {64'h0, 64'h0, 64'h0,
                                                   64'h0000_0001_8000_0000,
                                                   64'h0000_0000_0000_C000,
                                                   64'h0000_0000_FEB0_0000},
   parameter int                    ROM_SZL2   = 16,
   parameter logic [31:0]           ROM_ADDR   = 32'hFED0_0000,
   parameter bit                    ROM_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [1:0]       wr_off,
   input  logic [2:0]       wr_len,
   input  logic [31:0]      wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [31:0]      rd_data
);

   localparam int SEL_W = $clog2(NREG);

   // elaboration-time parameter checks
   if (NREG < 16 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 16");
   end
   if ((1 << IDX_W) <= NREG) begin : g_bad_idxw
      $error("IDX_W must reach past the last register");
   end
   if (HDR_TYPE > 1 || HDR_TYPE < 0) begin : g_bad_hdr
      $error("HDR_TYPE must be 0 or 1");
   end
   if (ROM_SZL2 != 0 && (ROM_SZL2 < ROM_ALIGN || ROM_SZL2 > 31)) begin : g_bad_rom
      $error("ROM size out of range");
   end
   for (genvar s = 0; s < NBAR; s++) begin : g_chk
      localparam logic [1:0] K  = BAR_KIND[2*s +: 2];
      localparam int         SN = (s < NBAR - 1) ? s + 1 : s;
      localparam int         Z  = int'(BAR_SZL2[8*s +: 8]);
      if (K == BK_MEM64 && (s == NBAR - 1 || BAR_KIND[2*SN +: 2] != BK_NONE)) begin : g_pair
         $error("64-bit slot needs a free following slot");
      end
      if ((K == BK_MEM32 && (Z < 4 || Z > 31)) ||
          (K == BK_IO    && (Z < 2 || Z > 31)) ||
          (K == BK_MEM64 && (Z < 4 || Z > 63))) begin : g_size
         $error("slot size out of range");
      end
      if (HDR_TYPE == 1 && s >= NBAR - 2 && K != BK_NONE) begin : g_bridge
         $error("bridge header needs the last slot free");
      end
   end

   logic [NREG-1:0][31:0] regs;
   logic [NREG-1:0][31:0] rst_val;
   logic [NREG-1:0][31:0] wmask;
   logic [NREG-1:0][31:0] qmask;
   logic [NREG-1:0][1:0]  qkind;

   for (genvar i = 0; i < NREG; i++) begin : g_attr
      cfg_reg_attr #(
         .IDX(i), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
         .CLASS_CODE(CLASS_CODE), .SUBCLASS(SUBCLASS), .PROG_IF(PROG_IF),
         .SUBSYS_VID(SUBSYS_VID), .SUBSYS_ID(SUBSYS_ID), .HDR_TYPE(HDR_TYPE),
         .BAR_KIND(BAR_KIND), .BAR_PREF(BAR_PREF), .BAR_SZL2(BAR_SZL2),
         .BAR_ADDR(BAR_ADDR), .ROM_SZL2(ROM_SZL2), .ROM_ADDR(ROM_ADDR),
         .ROM_EN(ROM_EN)
      ) u_attr (
         .rst_val(rst_val[i]),
         .wmask  (wmask[i]),
         .qmask  (qmask[i]),
         .qkind  (qkind[i])
      );
   end

   logic             wr_in_range;
   logic [SEL_W-1:0] wsel;
   logic [31:0]      merged;
   logic             merge_ok;

   assign wr_in_range = (wr_idx < IDX_W'(NREG));
   assign wsel        = wr_idx[SEL_W-1:0];

   cfg_write_merge u_merge (
      .cur  (regs[wsel]),
      .wdata(wr_data),
      .wmask(wmask[wsel]),
      .qmask(qmask[wsel]),
      .qkind(qkind[wsel]),
      .off  (wr_off),
      .len  (wr_len),
      .nxt  (merged),
      .take (merge_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs <= rst_val;
      end else if (wr_en && wr_in_range && merge_ok) begin
         regs[wsel] <= merged;
      end
   end

   always_comb begin
      if (rd_idx < IDX_W'(NREG)) rd_data = regs[rd_idx[SEL_W-1:0]];
      else                       rd_data = 32'hFFFF_FFFF;
   end

endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
   parameter int NREG  = 64,
   parameter int IDX_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic [IDX_W-1:0]      wr_idx,
   input logic [1:0]            wr_off,
   input logic [2:0]            wr_len,
   input logic [IDX_W-1:0]      rd_idx,
   input logic [31:0]           rd_data,
   input logic [NREG-1:0][31:0] regs
);

   logic [3:0] span;
   logic       bad_shape;
   assign span      = {2'b00, wr_off} + {1'b0, wr_len};
   assign bad_shape = (wr_len != 3'd1 && wr_len != 3'd2 && wr_len != 3'd4) ||
                      (span > 4'd4) || (wr_len == 3'd2 && wr_off[0]);

   assert_oob_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx >= IDX_W'(NREG)) |-> (rd_data == 32'hFFFF_FFFF));

   assert_oob_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx >= IDX_W'(NREG)) |=> $stable(regs));

   assert_bad_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bad_shape) |=> $stable(regs));

   assert_ident_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(regs[0]) && $stable(regs[2]) && $stable(regs[11]));

   assert_ro_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(regs[1][31:16]) && $stable(regs[3][31:8]));

endmodule

bind cfg_space cfg_space_chk #(.NREG(NREG), .IDX_W(IDX_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .wr_idx (wr_idx),
   .wr_off (wr_off),
   .wr_len (wr_len),
   .rd_idx (rd_idx),
   .rd_data(rd_data),
   .regs   (regs)
);

// File: tb/sim_cfg_space.sv
module sim_cfg_space;

   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        wr;
      logic [7:0]  idx;
      logic [1:0]  off;
      logic [2:0]  len;
      logic [31:0] data;
      logic [7:0]  ridx;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 42;
   localparam vec_t VEC [NV] = '{
      // R1 identity and read-only fields
      '{1'b0, 8'd0,  2'd0, 3'd4, 32'h0,         8'd0,   32'h5A17_C0DE, 4'd1},
      '{1'b0, 8'd0,  2'd0, 3'd4, 32'h0,         8'd2,   32'h0401_0000, 4'd1},
      '{1'b0, 8'd0,  2'd0, 3'd4, 32'h0,         8'd11,  32'h0042_7E11, 4'd1},
      '{1'b0, 8'd0,  2'd0, 3'd4, 32'h0,         8'd3,   32'h0000_0000, 4'd1},
      '{1'b1, 8'd0,  2'd0, 3'd4, 32'hFFFF_FFFF, 8'd0,   32'h5A17_C0DE, 4'd1},
      '{1'b1, 8'd2,  2'd0, 3'd4, 32'h0,         8'd2,   32'h0401_0000, 4'd1},
      // R3 command and cache line masks, R10 word merge
      '{1'b1, 8'd1,  2'd0, 3'd4, 32'hFFFF_FFFF, 8'd1,   32'h0000_FFFF, 4'd3},
      '{1'b1, 8'd1,  2'd2, 3'd2, 32'h0000_1234, 8'd1,   32'h0000_FFFF, 4'd10},
      '{1'b1, 8'd1,  2'd0, 3'd2, 32'h0000_ABCD, 8'd1,   32'h0000_ABCD, 4'd10},
      '{1'b1, 8'd3,  2'd0, 3'd4, 32'hFFFF_FFFF, 8'd3,   32'h0000_00FF, 4'd3},
      // R4 device-header interrupt line
      '{1'b1, 8'd15, 2'd0, 3'd4, 32'hFFFF_FFFF, 8'd15,  32'h0000_00FF, 4'd4},
      // R5 slot reset values, R6 upper half
      '{1'b0, 8'd0,  2'd0, 3'd4, 32'h0,         8'd4,   32'hFEB0_0000, 4'd5},
      '{1'b0, 8'd0,  2'd0, 3'd4, 32'h0,         8'd5,   32'h0000_C001, 4'd5},
      '{1'b0, 8'd0,  2'd0, 3'd4, 32'h0,         8'd6,   32'h8000_000C, 4'd5},
      '{1'b0, 8'd0,  2'd0, 3'd4, 32'h0,         8'd7,   32'h0000_0001, 4'd6},
      // R7 size query and near-miss, R12 byte writes are never queries
      '{1'b1, 8'd4,  2'd0, 3'd4, 32'hFFFF_FFFF, 8'd4,   32'h0000_1000, 4'd7},
      '{1'b1, 8'd4,  2'd0, 3'd4, 32'h1234_5678, 8'd4,   32'h1234_5670, 4'd5},
      '{1'b1, 8'd4,  2'd0, 3'd4, 32'hFFFF_FFFE, 8'd4,   32'hFFFF_FFF0, 4'd7},
      '{1'b1, 8'd4,  2'd1, 3'd1, 32'h0000_0000, 8'd4,   32'hFFFF_00F0, 4'd10},
      '{1'b1, 8'd4,  2'd1, 3'd1, 32'h0000_00FF, 8'd4,   32'hFFFF_FFF0, 4'd12},
      '{1'b1, 8'd5,  2'd0, 3'd4, 32'hFFFF_FFFF, 8'd5,   32'h0000_0021, 4'd7},
      '{1'b1, 8'd5,  2'd0, 3'd4, 32'h0000_ABCD, 8'd5,   32'h0000_ABCD, 4'd5},
      '{1'b1, 8'd6,  2'd0, 3'd4, 32'hFFFF_FFFF, 8'd6,   32'h0010_000C, 4'd7},
      '{1'b1, 8'd7,  2'd0, 3'd4, 32'hFFFF_FFFF, 8'd7,   32'h0000_0000, 4'd7},
      '{1'b1, 8'd7,  2'd3, 3'd1, 32'h0000_00A5, 8'd7,   32'hA500_0000, 4'd6},
      '{1'b1, 8'd7,  2'd0, 3'd4, 32'h1234_5678, 8'd7,   32'h1234_5678, 4'd6},
      // R11 unused slot
      '{1'b1, 8'd8,  2'd0, 3'd4, 32'hFFFF_FFFF, 8'd8,   32'h0000_0000, 4'd11},
      '{1'b1, 8'd8,  2'd0, 3'd4, 32'h5555_AAAA, 8'd8,   32'h0000_0000, 4'd11},
      // R8 ROM register
      '{1'b0, 8'd0,  2'd0, 3'd4, 32'h0,         8'd12,  32'hFED0_0001, 4'd8},
      '{1'b1, 8'd12, 2'd0, 3'd4, 32'hFFFF_F800, 8'd12,  32'h0001_0001, 4'd8},
      '{1'b1, 8'd12, 2'd0, 3'd4, 32'h1234_5678, 8'd12,  32'h1234_5001, 4'd8},
      '{1'b1, 8'd12, 2'd0, 3'd4, 32'hFFFF_F9FF, 8'd12,  32'h0001_0001, 4'd8},
      // R9 discarded shapes aimed at writable command bits
      '{1'b1, 8'd1,  2'd1, 3'd2, 32'h0000_0011, 8'd1,   32'h0000_ABCD, 4'd9},
      '{1'b1, 8'd1,  2'd1, 3'd4, 32'hFFFF_FFFF, 8'd1,   32'h0000_ABCD, 4'd9},
      '{1'b1, 8'd1,  2'd0, 3'd3, 32'hFFFF_FFFF, 8'd1,   32'h0000_ABCD, 4'd9},
      '{1'b1, 8'd1,  2'd3, 3'd2, 32'hFFFF_FFFF, 8'd1,   32'h0000_ABCD, 4'd9},
      '{1'b1, 8'd1,  2'd1, 3'd1, 32'h0000_0077, 8'd1,   32'h0000_77CD, 4'd10},
      // R2 range and undefined registers
      '{1'b1, 8'd65, 2'd0, 3'd4, 32'h0,         8'd1,   32'h0000_77CD, 4'd2},
      '{1'b0, 8'd0,  2'd0, 3'd4, 32'h0,         8'd64,  32'hFFFF_FFFF, 4'd2},
      '{1'b0, 8'd0,  2'd0, 3'd4, 32'h0,         8'd255, 32'hFFFF_FFFF, 4'd2},
      '{1'b1, 8'd20, 2'd0, 3'd4, 32'hDEAD_BEEF, 8'd20,  32'h0000_0000, 4'd2},
      // R10 word to upper half of a queried slot
      '{1'b1, 8'd6,  2'd2, 3'd2, 32'h0000_FFFF, 8'd6,   32'hFFFF_000C, 4'd10}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [7:0]  wr_idx;
   logic [1:0]  wr_off;
   logic [2:0]  wr_len;
   logic [31:0] wr_data;
   logic [7:0]  rd_idx;
   logic [31:0] rd0;
   logic [31:0] rd1;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cfg_space u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off),
      .wr_len(wr_len), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd0)
   );

   cfg_space #(.HDR_TYPE(1)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_off(wr_off),
      .wr_len(wr_len), .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd1)
   );

   task automatic do_write(input logic [7:0] i, input logic [1:0] o,
                           input logic [2:0] l, input logic [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_idx  = i;
      wr_off  = o;
      wr_len  = l;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic check(input logic [7:0] i, input logic [31:0] exp,
                        input int req, input bit bridge);
      logic [31:0] got;
      rd_idx = i;
      #1;
      got = bridge ? rd1 : rd0;
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL R%0d dut%0d reg %0d: got %h expected %h", req, bridge, i, got, exp);
      end
   endtask

   initial begin
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      wr_idx  = '0;
      wr_off  = '0;
      wr_len  = 3'd4;
      wr_data = '0;
      rd_idx  = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R4 bridge header type before any write
      check(8'd3, 32'h0001_0000, 4, 1'b1);

      for (int v = 0; v < NV; v++) begin
         if (VEC[v].wr) do_write(VEC[v].idx, VEC[v].off, VEC[v].len, VEC[v].data);
         check(VEC[v].ridx, VEC[v].exp, int'(VEC[v].req), 1'b0);
      end

      // R3 bridge keeps header type under a full write of register 3
      check(8'd3, 32'h0001_00FF, 3, 1'b1);
      // R4 bridge masks on registers 9 and 15
      do_write(8'd9, 2'd0, 3'd4, 32'hFFFF_FFFF);
      check(8'd9, 32'hFFF0_FFF0, 4, 1'b1);
      check(8'd9, 32'h0000_0000, 11, 1'b0);
      do_write(8'd15, 2'd0, 3'd4, 32'hFFFF_FFFF);
      check(8'd15, 32'hFFFF_00FF, 4, 1'b1);
      check(8'd15, 32'h0000_00FF, 4, 1'b0);

      // R1 R5 R8 reset restores parameter values mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check(8'd1,  32'h0000_0000, 1, 1'b0);
      check(8'd4,  32'hFEB0_0000, 5, 1'b0);
      check(8'd7,  32'h0000_0001, 6, 1'b0);
      check(8'd12, 32'hFED0_0001, 8, 1'b0);
      check(8'd9,  32'h0000_0000, 4, 1'b1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got still running, expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule